// File: doc/BRIEF.md
# Dual-Side Host Port Data Channel

This block is a parallel port that carries 16-bit words between a local processor and an external host with an 8-bit data bus. In the outbound direction the local side writes a whole word, and the host picks it up as two bytes, high and then low. In the inbound direction the host writes a high byte and then a low byte, and the local side receives the packed word. A small register file on the host side gives a control register, a status register and the two byte windows. Flags on both sides handle the handshake.

The local side can service outbound traffic in two ways: an interrupt that fires while the transmit register is empty, or a DMA request that makes it write the next word on its own. The host can also switch the port into a DMA mode. In that mode the port raises a request toward an external DMA controller whenever a word is waiting. The controller then collects the bytes with an acknowledge strobe. While this mode is on, addressed host reads of the receive byte windows are blocked, so that host software cannot take bytes away from the DMA controller. The port runs on a single clock with synchronous active-low reset. Any clock-domain crossing is handled outside the block.

Top module: `hp_port`

## Requirements
- R1: After reset, `loc_tx_empty` is 1. The status register (address 1) reads 0x02: bit0 receive-full is 0, bit1 host-may-write is 1, bit2 DMA-active is 0. The control register (address 0) reads 0x00, and `loc_irq_tx`, `loc_dreq_tx` and `hst_req` are 0.
- R2: A local word write while receive-full is clear takes effect on the next clock edge. Address 6 then reads the word's bits 15:8 and address 7 reads bits 7:0, status bit0 becomes 1 and `loc_tx_empty` becomes 0. A local write while receive-full is set is ignored, and the byte windows keep the earlier word.
- R3: An unblocked host read of address 7 while receive-full is set clears receive-full at that clock edge. `loc_tx_empty` rises one cycle later. A read of address 6 changes no flag.
- R4: `loc_irq_tx` is 1 exactly while the transmit-interrupt enable (local config bit0) is set, local DMA enable is clear, and `loc_tx_empty` is 1.
- R5: With local DMA enable (local config bit1) set, `loc_dreq_tx` follows `loc_tx_empty` and `loc_irq_tx` stays 0.
- R6: A host write to the control register with bit1 set sets `loc_tx_empty` and clears receive-full at that edge. Any pending local request therefore shows in the next cycle. Bit1 always reads back 0, and the other bits read back as written.
- R7: Control bits 3:2 select the host DMA mode (00 off, 01 and 11 word, 10 low byte only). Control bit0 is the receive request enable. `hst_req` is 1 when the mode is not off, the request enable is set and receive-full is set. With the mode off, `hst_req` stays 0.
- R8: While the DMA mode is on, host reads of addresses 6 and 7 return 0 and leave every flag unchanged. Control reads and writes, status reads and host byte writes keep working.
- R9: In word mode the first `hst_ack` returns the high byte and the second returns the low byte and clears receive-full. In byte mode a single acknowledge returns the low byte and clears receive-full. An acknowledge with the mode off is ignored.
- R10: A host write to address 6 and then to address 7 presents `{high, low}` on `loc_rx_word`, with `loc_rx_valid` set one cycle after the low write. Status bit1 reads as the inverse of `loc_rx_valid`, and `loc_rd` clears `loc_rx_valid`.
- R11: Host writes to addresses 6 and 7 while `loc_rx_valid` is set are ignored.
- R12: Writing 0 to the control register ends the DMA mode. Reads of addresses 6 and 7 then return the stored bytes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_wr | input | 1 | Local word write strobe |
| loc_wdata | input | 16 | Local outbound word |
| loc_rd | input | 1 | Local read strobe for the inbound word |
| loc_rx_word | output | 16 | Inbound word packed from host bytes |
| loc_rx_valid | output | 1 | Inbound word waiting |
| loc_cfg_wr | input | 1 | Local config write strobe |
| loc_cfg | input | 2 | bit0 transmit-interrupt enable, bit1 local DMA enable |
| loc_tx_empty | output | 1 | Local transmit register empty |
| loc_irq_tx | output | 1 | Local transmit interrupt |
| loc_dreq_tx | output | 1 | Local transmit DMA request |
| hst_addr | input | 3 | Host register address |
| hst_cs | input | 1 | Host chip select, active high |
| hst_rw | input | 1 | 1 read, 0 write |
| hst_ds | input | 1 | Host data strobe, one cycle per access |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid while the strobe or acknowledge is high |
| hst_ack | input | 1 | External DMA acknowledge read |
| hst_req | output | 1 | Host-side DMA request |

## Verification
Every flag and stored byte changes at the clock edge that samples the strobe. The bench drives each strobe from one falling edge to the next and checks the registered results at the falling edge after the sampling edge. It reads host data combinationally while the strobe is still high. The one two-step result is `loc_tx_empty` after a low-byte read: it is checked as still 0 at the first falling edge and as 1 one cycle later. `loc_irq_tx`, `loc_dreq_tx` and `hst_req` are combinational from registered flags, so they are checked in the same half-cycle as the flag they follow. The checks against ignored writes and blocked reads read back the byte windows, the status register or the inbound word before the next stimulus.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
// hp_pkg: shared constants and types for the host port data channel.
// Assumes a 3-bit host address and an 8-bit host control register layout.
package hp_pkg;
    localparam int HOST_AW = 3;

    localparam logic [HOST_AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [HOST_AW-1:0] ADR_STAT = 3'd1;
    localparam logic [HOST_AW-1:0] ADR_HI   = 3'd6;
    localparam logic [HOST_AW-1:0] ADR_LO   = 3'd7;

    // control register bit positions
    localparam int CB_RREQ  = 0;
    localparam int CB_INIT  = 1;
    localparam int CB_MODE0 = 2;
    localparam int CB_MODE1 = 3;

    // status register bit positions
    localparam int SB_RXFULL = 0;
    localparam int SB_HTXMT  = 1;
    localparam int SB_DMA    = 2;

    typedef enum logic [1:0] {
        XM_OFF   = 2'b00,
        XM_WORD  = 2'b01,
        XM_BYTE  = 2'b10,
        XM_WORD2 = 2'b11
    } xfer_mode_e;
endpackage

// File: rtl/hp_ctrl_regs.sv
`timescale 1ns/1ps
// hp_ctrl_regs: host control register and local config bits.
// The host control register stores every written bit except the init bit.
// The init bit is a one-cycle command pulse. The local config bits are
// written by a strobe from the local side.
// Assumes: wr_ctrl is a single-cycle decoded host write.
module hp_ctrl_regs
    import hp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg,
    output logic [BYTE_W-1:0] ctrl_rd,
    output logic              rreq,
    output xfer_mode_e        mode,
    output logic              dma_active,
    output logic              init,
    output logic              tie,
    output logic              tdma
);
    localparam logic [BYTE_W-1:0] INIT_MASK = BYTE_W'(1) << CB_INIT;

    logic [BYTE_W-1:0] ctrl_q;

    // host control register: store written value with the init bit dropped
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & ~INIT_MASK;
    end

    // local config bits: interrupt enable and local DMA enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie  <= 1'b0;
            tdma <= 1'b0;
        end else if (cfg_wr) begin
            tie  <= cfg[0];
            tdma <= cfg[1];
        end
    end

    // field decode of the stored control value
    always_comb begin
        ctrl_rd    = ctrl_q;
        rreq       = ctrl_q[CB_RREQ];
        mode       = xfer_mode_e'({ctrl_q[CB_MODE1], ctrl_q[CB_MODE0]});
        dma_active = (mode != XM_OFF);
        init       = wr_ctrl & wdata[CB_INIT];
    end

    // R6: the init bit is never stored
    p_init_not_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !ctrl_rd[CB_INIT]);
endmodule

// File: rtl/hp_out_path.sv
`timescale 1ns/1ps
// hp_out_path: local-to-host direction. Holds the two receive byte windows,
// the receive-full and transmit-empty flags, and the byte pointer used by DMA
// acknowledge reads.
// Assumes: rd_lo and ack arrive already qualified by the access gating.
// Priority at an edge: init, then consumption, then local write.
module hp_out_path #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_wr,
    input  logic [WORD_W-1:0] loc_wdata,
    input  logic              init,
    input  logic              rd_lo,
    input  logic              ack,
    input  logic              word_mode,
    output logic [BYTE_W-1:0] rx_hi,
    output logic [BYTE_W-1:0] rx_lo,
    output logic [BYTE_W-1:0] ack_data,
    output logic              rx_full,
    output logic              tx_empty
);
    logic hi_done;
    logic refill_pend;
    logic wr_acc;
    logic consume;
    logic ack_hi;

    // qualify local writes, consuming reads and high-byte acknowledges
    always_comb begin
        wr_acc   = loc_wr & ~rx_full & ~init;
        ack_hi   = ack & rx_full & word_mode & ~hi_done;
        consume  = rx_full & ~init & (rd_lo | (ack & ~ack_hi));
        ack_data = (word_mode && !hi_done) ? rx_hi : rx_lo;
    end

    // receive byte windows: loaded by an accepted local word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hi <= '0;
            rx_lo <= '0;
        end else if (wr_acc) begin
            rx_hi <= loc_wdata[WORD_W-1:BYTE_W];
            rx_lo <= loc_wdata[BYTE_W-1:0];
        end
    end

    // receive-full flag: set by an accepted write, cleared by init or consumption
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_full <= 1'b0;
        else if (init)    rx_full <= 1'b0;
        else if (consume) rx_full <= 1'b0;
        else if (wr_acc)  rx_full <= 1'b1;
    end

    // transmit-empty flag: set by init at once, or one cycle after consumption
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty    <= 1'b1;
            refill_pend <= 1'b0;
        end else if (init) begin
            tx_empty    <= 1'b1;
            refill_pend <= 1'b0;
        end else if (wr_acc) begin
            tx_empty    <= 1'b0;
            refill_pend <= 1'b0;
        end else begin
            if (refill_pend) tx_empty <= 1'b1;
            refill_pend <= consume;
        end
    end

    // DMA byte pointer: marks that the high byte went out in word mode
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_done <= 1'b0;
        else if (init || wr_acc || consume) hi_done <= 1'b0;
        else if (ack_hi)                    hi_done <= 1'b1;
    end

    // R2: an accepted word fills the windows and empties nothing twice
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (rx_full && !tx_empty));
    // R2: a write while full leaves the windows alone
    p_full_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && rx_full) |=> ($stable(rx_hi) && $stable(rx_lo)));
    // R3: a consumed word frees the channel on the next edge
    p_consume_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (!rx_full && !tx_empty));
    // R3: the refill arrives one cycle after consumption unless a word came in
    p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_pend && !wr_acc) |=> tx_empty);
    // R6: init frees both flags
    p_init_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (tx_empty && !rx_full));
endmodule

// File: rtl/hp_in_path.sv
`timescale 1ns/1ps
// hp_in_path: host-to-local direction. Packs a high byte and a low byte
// written by the host into one word for the local side.
// Assumes: wr_hi and wr_lo are single-cycle decoded host writes.
module hp_in_path #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              loc_rd,
    output logic [WORD_W-1:0] loc_word,
    output logic              loc_valid
);
    logic [BYTE_W-1:0] hi_hold;

    // high byte holding register, written only while the local side is free
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_hold <= '0;
        else if (wr_hi && !loc_valid) hi_hold <= wdata;
    end

    // packed word and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_word  <= '0;
            loc_valid <= 1'b0;
        end else if (loc_valid) begin
            if (loc_rd) loc_valid <= 1'b0;
        end else if (wr_lo) begin
            loc_word  <= {hi_hold, wdata};
            loc_valid <= 1'b1;
        end
    end

    // R10: a low-byte write into a free channel presents a word
    p_pack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !loc_valid) |=> loc_valid);
    // R11: a waiting word is not overwritten by the host
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_rd) |=> (loc_valid && $stable(loc_word)));
endmodule

// File: rtl/hp_port.sv
`timescale 1ns/1ps
// hp_port: top of the host port data channel. Decodes host accesses, applies
// the DMA-mode gating to the receive byte windows, builds the status register
// and the read data, and derives the local interrupt, the local DMA request
// and the host request.
// Assumes: one clock, synchronous active-low reset, and host strobes that are
// already synchronous and last one cycle per access.
module hp_port
    import hp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                loc_wr,
    input  logic [WORD_W-1:0]   loc_wdata,
    input  logic                loc_rd,
    output logic [WORD_W-1:0]   loc_rx_word,
    output logic                loc_rx_valid,
    input  logic                loc_cfg_wr,
    input  logic [1:0]          loc_cfg,
    output logic                loc_tx_empty,
    output logic                loc_irq_tx,
    output logic                loc_dreq_tx,
    input  logic [HOST_AW-1:0]  hst_addr,
    input  logic                hst_cs,
    input  logic                hst_rw,
    input  logic                hst_ds,
    input  logic [BYTE_W-1:0]   hst_wdata,
    output logic [BYTE_W-1:0]   hst_rdata,
    input  logic                hst_ack,
    output logic                hst_req
);
    logic              h_rd, h_wr;
    logic              wr_ctrl, wr_hi, wr_lo, rd_lo_ok;
    logic              ack_eff, word_mode;
    logic [BYTE_W-1:0] ctrl_rd, stat_rd, rx_hi, rx_lo, ack_data;
    logic              rreq, dma_active, init, tie, tdma, rx_full;
    xfer_mode_e        mode;

    // host access decode and DMA-mode gating
    always_comb begin
        h_rd      = hst_cs & hst_ds & hst_rw;
        h_wr      = hst_cs & hst_ds & ~hst_rw;
        wr_ctrl   = h_wr & (hst_addr == ADR_CTRL);
        wr_hi     = h_wr & (hst_addr == ADR_HI);
        wr_lo     = h_wr & (hst_addr == ADR_LO);
        rd_lo_ok  = h_rd & (hst_addr == ADR_LO) & ~dma_active;
        ack_eff   = hst_ack & dma_active;
        word_mode = (mode == XM_WORD) || (mode == XM_WORD2);
    end

    hp_ctrl_regs #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (hst_wdata),
        .cfg_wr     (loc_cfg_wr),
        .cfg        (loc_cfg),
        .ctrl_rd    (ctrl_rd),
        .rreq       (rreq),
        .mode       (mode),
        .dma_active (dma_active),
        .init       (init),
        .tie        (tie),
        .tdma       (tdma)
    );

    hp_out_path #(.BYTE_W(BYTE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_wr    (loc_wr),
        .loc_wdata (loc_wdata),
        .init      (init),
        .rd_lo     (rd_lo_ok),
        .ack       (ack_eff),
        .word_mode (word_mode),
        .rx_hi     (rx_hi),
        .rx_lo     (rx_lo),
        .ack_data  (ack_data),
        .rx_full   (rx_full),
        .tx_empty  (loc_tx_empty)
    );

    hp_in_path #(.BYTE_W(BYTE_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wdata     (hst_wdata),
        .loc_rd    (loc_rd),
        .loc_word  (loc_rx_word),
        .loc_valid (loc_rx_valid)
    );

    // status register assembly
    always_comb begin
        stat_rd            = '0;
        stat_rd[SB_RXFULL] = rx_full;
        stat_rd[SB_HTXMT]  = ~loc_rx_valid;
        stat_rd[SB_DMA]    = dma_active;
    end

    // host read data: acknowledge first, then addressed registers
    always_comb begin
        hst_rdata = '0;
        if (ack_eff) begin
            hst_rdata = ack_data;
        end else if (h_rd) begin
            case (hst_addr)
                ADR_CTRL: hst_rdata = ctrl_rd;
                ADR_STAT: hst_rdata = stat_rd;
                ADR_HI:   hst_rdata = dma_active ? '0 : rx_hi;
                ADR_LO:   hst_rdata = dma_active ? '0 : rx_lo;
                default:  hst_rdata = '0;
            endcase
        end
    end

    // request outputs toward the local processor and the external controller
    always_comb begin
        loc_irq_tx  = tie & ~tdma & loc_tx_empty;
        loc_dreq_tx = tdma & loc_tx_empty;
        hst_req     = dma_active & rreq & rx_full;
    end

    // R5: interrupt and local DMA request never together
    p_irq_or_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_irq_tx && loc_dreq_tx));
    // R7: a byte-mode acknowledge drops the host request
    p_req_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && ack_eff && !word_mode) |=> !hst_req);
    // R8: a blocked window read changes no flag
    p_blocked_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && dma_active && (hst_addr == ADR_LO) && !hst_ack && !loc_wr)
        |=> ($stable(rx_full) && $stable(loc_tx_empty)));
    // R9: an acknowledge with DMA off changes no flag
    p_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_ack && !dma_active && !h_rd && !h_wr && !loc_wr)
        |=> $stable(rx_full));
endmodule

// File: tb/tb_hp_port.sv
`timescale 1ns/1ps
module tb_hp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_wr = 1'b0;
    logic [15:0] loc_wdata = '0;
    logic        loc_rd = 1'b0;
    logic [15:0] loc_rx_word;
    logic        loc_rx_valid;
    logic        loc_cfg_wr = 1'b0;
    logic [1:0]  loc_cfg = '0;
    logic        loc_tx_empty, loc_irq_tx, loc_dreq_tx;
    logic [2:0]  hst_addr = '0;
    logic        hst_cs = 1'b0, hst_rw = 1'b0, hst_ds = 1'b0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        hst_ack = 1'b0;
    logic        hst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hp_port dut (
        .clk(clk), .rst_n(rst_n),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rd(loc_rd),
        .loc_rx_word(loc_rx_word), .loc_rx_valid(loc_rx_valid),
        .loc_cfg_wr(loc_cfg_wr), .loc_cfg(loc_cfg),
        .loc_tx_empty(loc_tx_empty), .loc_irq_tx(loc_irq_tx), .loc_dreq_tx(loc_dreq_tx),
        .hst_addr(hst_addr), .hst_cs(hst_cs), .hst_rw(hst_rw), .hst_ds(hst_ds),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ack(hst_ack), .hst_req(hst_req)
    );

    localparam logic [15:0] VEC [4] = '{16'hA55A, 16'h1234, 16'hFF00, 16'h00FF};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        hst_addr = a; hst_rw = 1'b1; hst_cs = 1'b1; hst_ds = 1'b1;
        #1 d = hst_rdata;
        tick();
        hst_cs = 1'b0; hst_ds = 1'b0;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        hst_addr = a; hst_rw = 1'b0; hst_wdata = d; hst_cs = 1'b1; hst_ds = 1'b1;
        tick();
        hst_cs = 1'b0; hst_ds = 1'b0;
    endtask

    task automatic host_ack(output logic [7:0] d);
        hst_ack = 1'b1;
        #1 d = hst_rdata;
        tick();
        hst_ack = 1'b0;
    endtask

    task automatic local_wr(input logic [15:0] w);
        loc_wr = 1'b1; loc_wdata = w;
        tick();
        loc_wr = 1'b0;
    endtask

    task automatic local_cfg(input logic [1:0] c);
        loc_cfg_wr = 1'b1; loc_cfg = c;
        tick();
        loc_cfg_wr = 1'b0;
    endtask

    task automatic local_rd();
        loc_rd = 1'b1;
        tick();
        loc_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 tx_empty", loc_tx_empty, 1);
        check("R1 irq/dreq/req", {loc_irq_tx, loc_dreq_tx, hst_req}, 0);
        host_rd(3'd1, d); check("R1 status", d, 8'h02);
        host_rd(3'd0, d); check("R1 ctrl", d, 8'h00);

        // R2/R3 vector walk: local word out, host collects both bytes
        for (int i = 0; i < 4; i++) begin
            local_wr(VEC[i]);
            check("R2 tx_empty low", loc_tx_empty, 0);
            host_rd(3'd1, d); check("R2 status full", d, 8'h03);
            host_rd(3'd6, d); check("R2 high byte", d, VEC[i][15:8]);
            host_rd(3'd1, d); check("R3 high read keeps full", d[0], 1);
            host_rd(3'd7, d); check("R2 low byte", d, VEC[i][7:0]);
            check("R3 tx_empty still low", loc_tx_empty, 0);
            host_rd(3'd1, d); check("R3 full cleared", d[0], 0);
            check("R3 tx_empty refilled", loc_tx_empty, 1);
        end

        // R2 write while full ignored
        local_wr(16'h1111);
        local_wr(16'h2222);
        host_rd(3'd6, d); check("R2 ignored hi", d, 8'h11);
        host_rd(3'd7, d); check("R2 ignored lo", d, 8'h11);
        tick();

        // R4 interrupt
        local_cfg(2'b01);
        check("R4 irq when empty", loc_irq_tx, 1);
        local_wr(16'h4455);
        check("R4 irq off when full", loc_irq_tx, 0);
        host_rd(3'd7, d);
        check("R4 irq still off", loc_irq_tx, 0);
        tick();
        check("R4 irq back", loc_irq_tx, 1);

        // R5 local DMA
        local_cfg(2'b11);
        check("R5 dreq", {loc_dreq_tx, loc_irq_tx}, 2'b10);
        local_wr(16'h6677);
        check("R5 dreq off", loc_dreq_tx, 0);

        // R6 init with a word pending
        host_wr(3'd0, 8'h02);
        check("R6 init tx_empty", loc_tx_empty, 1);
        check("R6 immediate dreq", loc_dreq_tx, 1);
        host_rd(3'd1, d); check("R6 full cleared", d[0], 0);
        host_rd(3'd0, d); check("R6 init reads 0", d, 8'h00);
        host_wr(3'd0, 8'hA2);
        host_rd(3'd0, d); check("R6 other bits kept", d, 8'hA0);
        host_wr(3'd0, 8'h00);
        local_cfg(2'b00);

        // R7 request enable with mode off
        host_wr(3'd0, 8'h01);
        local_wr(16'h0102);
        check("R7 no req mode off", hst_req, 0);
        host_rd(3'd7, d); tick();

        // R7/R8 word DMA mode
        host_wr(3'd0, 8'h05);
        local_wr(16'hBEEF);
        check("R7 req in dma", hst_req, 1);
        host_rd(3'd1, d); check("R8 status dma", d, 8'h07);
        host_rd(3'd6, d); check("R8 blocked hi", d, 8'h00);
        host_rd(3'd7, d); check("R8 blocked lo", d, 8'h00);
        host_rd(3'd1, d); check("R8 flags unchanged", d[0], 1);
        check("R8 tx_empty unchanged", loc_tx_empty, 0);
        host_wr(3'd6, 8'h3C);
        host_rd(3'd0, d); check("R8 ctrl readable", d, 8'h05);

        // R9 word-mode acknowledges
        host_ack(d); check("R9 ack hi", d, 8'hBE);
        check("R9 req after first ack", hst_req, 1);
        host_ack(d); check("R9 ack lo", d, 8'hEF);
        check("R9 req dropped", hst_req, 0);
        tick();
        check("R9 tx_empty after ack", loc_tx_empty, 1);

        // R9 byte mode
        host_wr(3'd0, 8'h09);
        local_wr(16'hCAFE);
        host_ack(d); check("R9 byte ack", d, 8'hFE);
        host_rd(3'd1, d); check("R9 byte ack clears", d[0], 0);

        // R12 leave DMA mode
        local_wr(16'h1357);
        host_wr(3'd0, 8'h00);
        check("R12 req off", hst_req, 0);
        host_rd(3'd6, d); check("R12 hi readable", d, 8'h13);
        host_rd(3'd7, d); check("R12 lo readable", d, 8'h57);
        tick();

        // R9 ack ignored with mode off
        local_wr(16'h2468);
        host_ack(d);
        host_rd(3'd1, d); check("R9 ack ignored", d[0], 1);
        host_rd(3'd6, d); check("R9 data intact", d, 8'h24);
        host_rd(3'd7, d); tick();

        // R10 host-to-local packing (high byte 3C written in DMA mode)
        check("R10 idle", loc_rx_valid, 0);
        host_wr(3'd7, 8'hC3);
        check("R10 valid", loc_rx_valid, 1);
        check("R10 word", loc_rx_word, 16'h3CC3);
        host_rd(3'd1, d); check("R10 status host-write bit", d[1], 0);

        // R11 writes while valid ignored
        host_wr(3'd6, 8'h99);
        host_wr(3'd7, 8'h66);
        check("R11 word kept", loc_rx_word, 16'h3CC3);
        local_rd();
        check("R10 valid cleared", loc_rx_valid, 0);
        host_rd(3'd1, d); check("R10 status free", d[1], 1);
        host_wr(3'd6, 8'h5A);
        host_wr(3'd7, 8'hA5);
        check("R11 fresh word after read", loc_rx_word, 16'h5AA5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule